// File: doc/BRIEF.md
# Left-Justified Stereo Audio Serial Slave Port

This block is a slave-only serial audio port for stereo PCM. An external device owns both the bit clock and the frame clock and cannot be reconfigured. The frame clock toggles once per sample period. The bit clock runs at 64 times the sample rate, which gives two 32-bit slots per frame. The framing is left-justified: the most significant bit of a slot is already on the data line in the bit period that begins with the frame-clock change. It does not arrive one bit later. Each incoming slot carries a 24-bit sample in its upper bits. The block keeps the 16 most significant of them and hands left/right pairs out on a valid/ready interface.

In the other direction, 16-bit left/right pairs enter through a one-entry valid/ready buffer. They are shifted out MSB first at the top of each slot, followed by zero padding. All serial inputs are brought into the system clock domain, and bit-clock edges are found there, so the system clock must run at least eight times faster than the bit clock.

Which frame-clock level means "left" is set by a configuration input. A loopback mode routes received pairs straight into the transmitter. Any master clock the external device provides is not used.

Top module: `lj_audio_slave`

## Requirements
- R1: After reset, out_valid, overrun, underrun and sdout are 0, and in_ready is 1.
- R2: Received data is sampled on bit-clock rising edges. The bit present at the first rising edge after a frame-clock change is bit 31 of the slot. Bits 31..16 of the slot are reported as the 16-bit sample, MSB first. Bits 15..0 have no effect on the result.
- R3: With frame_pol = 0, the slot sent while the frame clock is high is the left channel. With frame_pol = 1, the slot sent while the frame clock is low is the left channel. A frame starts with its left slot.
- R4: After reset, nothing is reported until a frame-clock change has been seen. The first reported pair is the first complete left slot plus right slot that follow that change.
- R5: A received pair is presented with out_valid = 1 once its right sample is complete. It stays presented until a cycle in which out_valid and out_ready are both 1.
- R6: If a new pair completes while the previous one is still untaken, the new pair replaces it and the sticky overrun output goes to 1. Overrun stays at 1 until reset.
- R7: The transmitter drives the 16-bit sample MSB first. Its MSB is on sdout from the bit-clock falling edge that accompanies the frame-clock change, and slot bits 15..0 are driven as 0. The left sample goes in the left slot and the right sample in the right slot.
- R8: in_ready is 1 while the one-entry transmit buffer is empty. A pair is accepted when in_valid and in_ready are both 1. The buffered pair is used at the next left slot start.
- R9: If the transmit buffer is empty at a left slot start, both slots of that frame are sent as all zeros, and the sticky underrun output goes to 1.
- R10: With loop_en = 1, each received pair is transmitted in the following frame. out_valid and in_ready are held at 0 at the ports.
- R11: sdout changes only after bit-clock falling edges, so it is stable across every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Bit clock from the external master |
| fclk_in | input | 1 | Frame clock from the external master |
| sdin | input | 1 | Serial data from the external device |
| sdout | output | 1 | Serial data to the external device |
| frame_pol | input | 1 | Frame-clock level of the left slot: 0 = high, 1 = low |
| loop_en | input | 1 | Route received pairs to the transmitter |
| out_valid | output | 1 | Received pair available |
| out_ready | input | 1 | Consumer takes the received pair |
| out_left | output | 16 | Received left sample |
| out_right | output | 16 | Received right sample |
| in_valid | input | 1 | Transmit pair offered |
| in_ready | output | 1 | Transmit buffer empty |
| in_left | input | 16 | Left sample to transmit |
| in_right | input | 16 | Right sample to transmit |
| overrun | output | 1 | Sticky: a received pair was overwritten |
| underrun | output | 1 | Sticky: a frame started with no transmit pair |

## Verification
Each serial input passes through two synchroniser flops and one edge-detect flop before the port logic registers it. A received pair therefore appears about four system cycles after the 16th rising bit-clock edge of its right slot. Likewise, each transmitted bit appears about four cycles after the falling edge that launches it. The bench models the master with 8-cycle bit-clock half periods. It reads sdout on the negative system-clock edge just before each bit-clock rise, and reads it again four cycles after the rise to confirm it has not moved. Results for the receive side, the flags and the handshakes are read only after a whole frame has been driven. By then every result for that frame is long due, and no bit of the following frame has arrived yet.

// File: rtl/lj_audio_pkg.sv
package lj_audio_pkg;
    localparam int SAMPLE_W    = 16;
    localparam int SLOT_BITS   = 32;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } stereo_t;

    // high when the synchronised frame clock marks the left slot
    function automatic logic slot_is_left(input logic fclk, input logic pol);
        return fclk ^ pol;
    endfunction
endpackage

// File: rtl/lj_edge_sync.sv
module lj_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_raw,
    input  logic fclk_raw,
    input  logic data_raw,
    output logic bit_rise,
    output logic bit_fall,
    output logic fclk_s,
    output logic data_s
);
    logic [STAGES:0]   bclk_q;
    logic [STAGES-1:0] fclk_q;
    logic [STAGES-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= '0;
            fclk_q <= '0;
            data_q <= '0;
        end else begin
            bclk_q[0] <= bclk_raw;
            fclk_q[0] <= fclk_raw;
            data_q[0] <= data_raw;
            bclk_q[STAGES] <= bclk_q[STAGES-1];
        end
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    bclk_q[g] <= 1'b0;
                    fclk_q[g] <= 1'b0;
                    data_q[g] <= 1'b0;
                end else begin
                    bclk_q[g] <= bclk_q[g-1];
                    fclk_q[g] <= fclk_q[g-1];
                    data_q[g] <= data_q[g-1];
                end
            end
        end
    endgenerate

    assign bit_rise = bclk_q[STAGES-1] & ~bclk_q[STAGES];
    assign bit_fall = ~bclk_q[STAGES-1] & bclk_q[STAGES];
    assign fclk_s   = fclk_q[STAGES-1];
    assign data_s   = data_q[STAGES-1];
endmodule

// File: rtl/lj_rx_deser.sv
module lj_rx_deser
    import lj_audio_pkg::*;
#(
    parameter int SLOT_W = SLOT_BITS
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_rise,
    input  logic    fclk_s,
    input  logic    data_s,
    input  logic    frame_pol,
    output logic    pair_valid,
    input  logic    pair_ready,
    output stereo_t pair,
    output logic    overrun
);
    localparam int CW = $clog2(SLOT_W) + 1;

    logic                seen, prev_left, cur_left, armed, have_left;
    logic [CW-1:0]       cnt;
    logic [SAMPLE_W-1:0] shreg, left_hold;
    logic                lr_now, slot_start, commit;
    logic [SAMPLE_W-1:0] word;

    assign lr_now     = slot_is_left(fclk_s, frame_pol);
    assign slot_start = seen && (lr_now != prev_left);
    assign commit     = armed && !slot_start && (cnt == CW'(SAMPLE_W - 1));
    assign word       = {shreg[SAMPLE_W-2:0], data_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            seen       <= 1'b0;
            prev_left  <= 1'b0;
            cur_left   <= 1'b0;
            armed      <= 1'b0;
            have_left  <= 1'b0;
            cnt        <= CW'(SLOT_W);
            shreg      <= '0;
            left_hold  <= '0;
            pair       <= '0;
            pair_valid <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            if (pair_valid && pair_ready)
                pair_valid <= 1'b0;
            if (bit_rise) begin
                seen      <= 1'b1;
                prev_left <= lr_now;
                if (slot_start) begin
                    armed    <= 1'b1;
                    cur_left <= lr_now;
                    shreg    <= {{(SAMPLE_W-1){1'b0}}, data_s};
                    cnt      <= CW'(1);
                end else begin
                    shreg <= word;
                    if (cnt < CW'(SLOT_W))
                        cnt <= cnt + CW'(1);
                end
                if (commit) begin
                    if (cur_left) begin
                        left_hold <= word;
                        have_left <= 1'b1;
                    end else if (have_left) begin
                        pair.left  <= left_hold;
                        pair.right <= word;
                        pair_valid <= 1'b1;
                        have_left  <= 1'b0;
                        if (pair_valid && !pair_ready)
                            overrun <= 1'b1;
                    end
                end
            end
        end
    end

    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    a_r5_hold_until_taken: assert property (@(posedge clk) disable iff (rst)
        (pair_valid && !pair_ready) |=> pair_valid);
endmodule

// File: rtl/lj_tx_ser.sv
module lj_tx_ser
    import lj_audio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_fall,
    input  logic    fclk_s,
    input  logic    frame_pol,
    input  logic    src_valid,
    output logic    src_ready,
    input  stereo_t src_pair,
    output logic    sd_out,
    output logic    underrun
);
    logic                seen, prev_left, buf_full;
    stereo_t             buf_pair;
    logic [SAMPLE_W-1:0] shreg, right_hold;
    logic                lr_now, slot_start;

    assign lr_now     = slot_is_left(fclk_s, frame_pol);
    assign slot_start = seen && (lr_now != prev_left);
    assign src_ready  = !buf_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen       <= 1'b0;
            prev_left  <= 1'b0;
            buf_full   <= 1'b0;
            buf_pair   <= '0;
            shreg      <= '0;
            right_hold <= '0;
            sd_out     <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            if (src_valid && src_ready) begin
                buf_pair <= src_pair;
                buf_full <= 1'b1;
            end
            if (bit_fall) begin
                seen      <= 1'b1;
                prev_left <= lr_now;
                if (slot_start && lr_now) begin
                    if (buf_full) begin
                        sd_out     <= buf_pair.left[SAMPLE_W-1];
                        shreg      <= {buf_pair.left[SAMPLE_W-2:0], 1'b0};
                        right_hold <= buf_pair.right;
                        buf_full   <= 1'b0;
                    end else begin
                        sd_out     <= 1'b0;
                        shreg      <= '0;
                        right_hold <= '0;
                        underrun   <= 1'b1;
                    end
                end else if (slot_start) begin
                    sd_out <= right_hold[SAMPLE_W-1];
                    shreg  <= {right_hold[SAMPLE_W-2:0], 1'b0};
                end else begin
                    sd_out <= shreg[SAMPLE_W-1];
                    shreg  <= {shreg[SAMPLE_W-2:0], 1'b0};
                end
            end
        end
    end

    a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    a_r8_accept_fills_buffer: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_ready) |=> !src_ready);

    a_r11_sdout_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        !bit_fall |=> $stable(sd_out));
endmodule

// File: rtl/lj_audio_slave.sv
module lj_audio_slave
    import lj_audio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bclk_in,
    input  logic                fclk_in,
    input  logic                sdin,
    output logic                sdout,
    input  logic                frame_pol,
    input  logic                loop_en,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                overrun,
    output logic                underrun
);
    logic    bit_rise, bit_fall, fclk_s, data_s;
    logic    rx_valid, rx_ready, tx_valid, tx_ready;
    stereo_t rx_pair, tx_pair, ext_pair;

    lj_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .bclk_raw (bclk_in),
        .fclk_raw (fclk_in),
        .data_raw (sdin),
        .bit_rise (bit_rise),
        .bit_fall (bit_fall),
        .fclk_s   (fclk_s),
        .data_s   (data_s)
    );

    lj_rx_deser #(.SLOT_W(SLOT_BITS)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .bit_rise   (bit_rise),
        .fclk_s     (fclk_s),
        .data_s     (data_s),
        .frame_pol  (frame_pol),
        .pair_valid (rx_valid),
        .pair_ready (rx_ready),
        .pair       (rx_pair),
        .overrun    (overrun)
    );

    assign ext_pair  = '{left: in_left, right: in_right};
    assign tx_valid  = loop_en ? rx_valid : in_valid;
    assign tx_pair   = loop_en ? rx_pair : ext_pair;
    assign rx_ready  = loop_en ? tx_ready : out_ready;
    assign out_valid = rx_valid & ~loop_en;
    assign in_ready  = tx_ready & ~loop_en;
    assign out_left  = rx_pair.left;
    assign out_right = rx_pair.right;

    lj_tx_ser u_tx (
        .clk       (clk),
        .rst       (rst),
        .bit_fall  (bit_fall),
        .fclk_s    (fclk_s),
        .frame_pol (frame_pol),
        .src_valid (tx_valid),
        .src_ready (tx_ready),
        .src_pair  (tx_pair),
        .sd_out    (sdout),
        .underrun  (underrun)
    );
endmodule

// File: tb/tb_lj_audio_slave.sv
module tb_lj_audio_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk_in = 1'b1, fclk_in = 1'b1, sdin = 1'b0;
    logic        frame_pol = 1'b0, loop_en = 1'b0;
    logic        out_ready = 1'b0, in_valid = 1'b0;
    logic [15:0] in_left = '0, in_right = '0;
    logic        sdout, out_valid, in_ready, overrun, underrun;
    logic [15:0] out_left, out_right;

    int total = 0;
    int bad   = 0;
    int glitches = 0;
    logic [31:0] cap_l, cap_r;

    always #4 clk = ~clk;

    lj_audio_slave dut (
        .clk(clk), .rst(rst), .bclk_in(bclk_in), .fclk_in(fclk_in), .sdin(sdin),
        .sdout(sdout), .frame_pol(frame_pol), .loop_en(loop_en),
        .out_valid(out_valid), .out_ready(out_ready), .out_left(out_left),
        .out_right(out_right), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .overrun(overrun), .underrun(underrun)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic pol, input logic lp);
        @(negedge clk);
        rst = 1'b1; frame_pol = pol; loop_en = lp;
        bclk_in = 1'b1; fclk_in = ~pol; sdin = 1'b0;
        out_ready = 1'b0; in_valid = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // one master frame: left slot then right slot, 8-cycle half periods
    task automatic run_frame(input logic [31:0] lw, input logic [31:0] rw);
        for (int i = 0; i < 64; i++) begin
            logic held;
            @(negedge clk);
            bclk_in = 1'b0;
            fclk_in = (i < 32) ? ~frame_pol : frame_pol;
            sdin    = (i < 32) ? lw[31 - i] : rw[31 - (i - 32)];
            repeat (7) @(negedge clk);
            held = sdout;
            if (i < 32) cap_l[31 - i] = sdout;
            else        cap_r[31 - (i - 32)] = sdout;
            bclk_in = 1'b1;
            repeat (4) @(negedge clk);
            if (sdout !== held) glitches++;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic push(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic test_reset();
        do_reset(1'b0, 1'b0);
        check(out_valid == 0 && overrun == 0 && underrun == 0, "R1 flags", 
              {out_valid, overrun, underrun}, 0);
        check(sdout == 0 && in_ready == 1, "R1 sdout/in_ready", {sdout, in_ready}, 1);
    endtask

    task automatic test_basic();
        do_reset(1'b0, 1'b0);
        push(16'h1234, 16'h8765);
        run_frame(32'hDEAD_BEEF, 32'h0BAD_F00D);
        check(out_valid == 0, "R4 warm frame discarded", out_valid, 0);
        fork
            run_frame(32'hA5C3_1E7F, 32'h5A3C_E1F7);
            push(16'hCAFE, 16'h0F0F);
        join
        check(out_valid == 1, "R5 pair valid", out_valid, 1);
        check({out_left, out_right} == 32'hA5C3_5A3C, "R2 R4 rx pair",
              {out_left, out_right}, 32'hA5C3_5A3C);
        check(cap_l == 32'h1234_0000 && cap_r == 32'h8765_0000, "R7 tx frame1",
              {cap_l, cap_r}, 64'h1234_0000_8765_0000);
        pop();
        check(out_valid == 0, "R5 taken", out_valid, 0);
        fork
            run_frame(32'h8001_FFFF, 32'h7FFE_0000);
            push(16'hF00D, 16'h0001);
        join
        check({out_left, out_right} == 32'h8001_7FFE, "R2 low bits ignored",
              {out_left, out_right}, 32'h8001_7FFE);
        check(cap_l == 32'hCAFE_0000 && cap_r == 32'h0F0F_0000, "R7 R8 tx frame2",
              {cap_l, cap_r}, 64'hCAFE_0000_0F0F_0000);
        pop();
        run_frame(32'h1111_2222, 32'h3333_4444);
        check(cap_l == 32'hF00D_0000 && cap_r == 32'h0001_0000, "R7 tx frame3",
              {cap_l, cap_r}, 64'hF00D_0000_0001_0000);
        check(overrun == 0 && underrun == 0, "R6 R9 no flags yet",
              {overrun, underrun}, 0);
        run_frame(32'h5555_6666, 32'h7777_8888);
        check(overrun == 1, "R6 overrun set", overrun, 1);
        check({out_left, out_right} == 32'h5555_7777, "R6 newer pair kept",
              {out_left, out_right}, 32'h5555_7777);
        check(underrun == 1, "R9 underrun set", underrun, 1);
        check(cap_l == 0 && cap_r == 0, "R9 zero frame", {cap_l, cap_r}, 0);
        check(in_ready == 1, "R8 buffer empty", in_ready, 1);
    endtask

    task automatic test_polarity();
        do_reset(1'b1, 1'b0);
        push(16'hABCD, 16'h4321);
        run_frame(32'h0, 32'h0);
        run_frame(32'hC0DE_0000, 32'h0123_0000);
        check({out_left, out_right} == 32'hC0DE_0123, "R3 inverted polarity rx",
              {out_left, out_right}, 32'hC0DE_0123);
        check(cap_l == 32'hABCD_0000 && cap_r == 32'h4321_0000, "R3 inverted polarity tx",
              {cap_l, cap_r}, 64'hABCD_0000_4321_0000);
    endtask

    task automatic test_loopback();
        do_reset(1'b0, 1'b1);
        run_frame(32'h0, 32'h0);
        run_frame(32'h9ABC_0000, 32'h2468_0000);
        check(out_valid == 0 && in_ready == 0, "R10 ports idle in loopback",
              {out_valid, in_ready}, 0);
        run_frame(32'h1357_0000, 32'hFDB9_0000);
        check(cap_l == 32'h9ABC_0000 && cap_r == 32'h2468_0000, "R10 looped pair",
              {cap_l, cap_r}, 64'h9ABC_0000_2468_0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_basic();
        test_polarity();
        test_loopback();
        check(glitches == 0, "R11 sdout stable at rising edges", glitches, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule